// File: doc/BRIEF.md
# Handshaked Byte-Bus Register Slave

This block is the FPGA-side end of an asynchronous 8-bit bidirectional link to an external microcontroller. The host frames each transaction with a short pulse on a start line. It then pushes a six-byte request over the shared byte bus and pulls back an eight-byte reply. Every byte moves under a four-phase, two-wire handshake. The host owns one strobe (`host_hs1`) and the slave owns the other (`hs2`). A separate direction line (`host_rw`) tells the slave whether the host is writing or reading.

All host-side control inputs are asynchronous. Each passes through a two-flop synchroniser before the transaction sequencer uses it. The request carries an opcode, a register index and a 32-bit word. The slave applies it to a small internal register file that stands in for peripheral registers, and answers with a data word and a status word. `ack` stays high from the detected start until the last reply byte has been fully handshaked. A low level on the host's own reset line aborts any transfer in progress and returns the sequencer to idle.

The bus pad is modelled as separate `bus_in`, `bus_out` and `bus_oe` signals, so the chip's pad ring forms the tri-state buffer.

Top module: `bytebus_reg_slave`

## Requirements
- R1: After the synchronous reset `rst`, `ack`, `hs2` and `bus_oe` are 0 and every register reads back as zero.
- R2: A rising edge on the synchronised `host_start`, seen while idle, starts a transaction and raises `ack`. A start pulse during a transaction has no effect on that transaction.
- R3: Host write byte: while `host_rw`=0, the slave captures `bus_in` only after it sees `host_hs1` high, then raises `hs2`. It lowers `hs2` only after it sees `host_hs1` low. `hs2` never rises before `host_hs1`.
- R4: The request is six bytes in this order: byte 0 is the opcode, byte 1 is the register index, bytes 2 to 5 are the 32-bit word, least significant byte first.
- R5: Host read byte: with `host_rw`=1 and `host_hs1` low, the slave presents a reply byte and raises `hs2`. It holds the byte stable until it sees `host_hs1` high, then lowers `hs2`. It offers the next byte only after `host_hs1` returns low.
- R6: The reply is eight bytes: the data word first, then the status word, each least significant byte first.
- R7: Opcode 0x01 writes the word to the indexed register and returns the new contents. Opcode 0x02 returns the register contents and leaves them unchanged.
- R8: Status bit 0 is set for any other opcode. Status bit 1 is set when the index is NREGS or above. Both bits may be set together. A request with either bit set changes no register and returns data 0. A good request returns status 0.
- R9: `ack` stays high through the whole transaction, including after `hs2` falls on the last reply byte. It falls once the slave sees `host_hs1` low after that byte.
- R10: `bus_oe` is 1 only while `host_rw` indicates read and the sequencer is in its reply phase. It is 0 during the request and whenever `host_rw`=0.
- R11: `host_rst_n` low aborts any transaction: `ack` and `hs2` fall and the sequencer returns to idle. Register contents are kept. A write whose request was fully received before the abort stays in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rst_n | input | 1 | Asynchronous active-low abort from the host |
| host_start | input | 1 | Asynchronous transaction start pulse |
| host_rw | input | 1 | Asynchronous direction: 0 host writes, 1 host reads |
| host_hs1 | input | 1 | Asynchronous host handshake strobe |
| bus_in | input | 8 | Byte bus as seen at the pad input |
| bus_out | output | 8 | Reply byte for the pad driver |
| bus_oe | output | 1 | Pad output enable |
| hs2 | output | 1 | Slave handshake strobe |
| ack | output | 1 | Transaction-in-progress flag |

## Verification
Two functions can fall into the same stretch of cycles here. One is the host abort. The other is the normal handshake or register commit it interrupts. The bench raises the abort once in the middle of the request bytes and once in the middle of the reply bytes. In each case it judges the outcome at the ports: `ack` and `hs2` must fall, and a later read must show the register untouched in the first case and updated in the second. A start pulse placed in the middle of a request is the second overlap. The bench judges it by checking that the reply still matches the original request.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int RX_BYTES = 2 + WORD_W / BYTE_W;
    localparam int TX_BYTES = 2 * WORD_W / BYTE_W;
    localparam int RX_BITS  = RX_BYTES * BYTE_W;
    localparam int TX_BITS  = TX_BYTES * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_WRITE = 8'h01;
    localparam logic [BYTE_W-1:0] OP_READ  = 8'h02;

    localparam int ST_BAD_OP   = 0;
    localparam int ST_BAD_ADDR = 1;

    typedef enum logic [2:0] {
        S_IDLE, S_RX_HI, S_RX_LO, S_EXEC, S_TX_ARM, S_TX_HI, S_TX_LO
    } phase_e;

    // request: opcode arrives first, so it sits at the low end of the shift register
    typedef struct packed {
        logic [WORD_W-1:0] wdata;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] op;
    } req_t;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] rdata;
    } rsp_t;

    function automatic logic [WORD_W-1:0] make_status(input logic [BYTE_W-1:0] op,
                                                      input logic [BYTE_W-1:0] addr,
                                                      input int unsigned nregs);
        logic [WORD_W-1:0] s;
        s = '0;
        s[ST_BAD_OP]   = (op != OP_WRITE) && (op != OP_READ);
        s[ST_BAD_ADDR] = (32'(addr) >= 32'(nregs));
        return s;
    endfunction

endpackage

// File: rtl/bbs_sync.sv
module bbs_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bbs_regfile.sv
module bbs_regfile #(
    parameter  int NREGS = 8,
    parameter  int DW    = 32,
    localparam int AW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && (waddr == AW'(g)))
                q <= wdata;
        end
        assign regs[g] = q;
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/bytebus_reg_slave.sv
module bytebus_reg_slave
    import bbs_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rst_n,
    input  logic              host_start,
    input  logic              host_rw,
    input  logic              host_hs1,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              hs2,
    output logic              ack
);
    localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam int IW = $clog2(TX_BYTES + 1);

    // synchronised host controls
    logic s_start, s_rw, s_hs1, s_rstn;
    logic start_q, start_edge;

    bbs_sync #(.W(3), .RST_VAL(3'b000)) u_sync_ctl (
        .clk (clk),
        .rst (rst),
        .d   ({host_start, host_rw, host_hs1}),
        .q   ({s_start, s_rw, s_hs1})
    );

    bbs_sync #(.W(1), .RST_VAL(1'b1)) u_sync_rst (
        .clk (clk),
        .rst (rst),
        .d   (host_rst_n),
        .q   (s_rstn)
    );

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= s_start;
    end
    assign start_edge = s_start & ~start_q;

    // sequencer
    phase_e              st, nxt;
    logic [IW-1:0]       idx;
    logic [RX_BITS-1:0]  rx_q;
    logic [TX_BITS-1:0]  tx_q;
    req_t                req;
    rsp_t                rsp_d;
    logic [WORD_W-1:0]   status_d, rf_rdata;
    logic                req_ok, rf_we;
    logic                rx_take, tx_done;

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:   if (start_edge)          nxt = S_RX_HI;
            S_RX_HI:  if (s_hs1 && !s_rw)      nxt = S_RX_LO;
            S_RX_LO:  if (!s_hs1)              nxt = (idx == IW'(RX_BYTES)) ? S_EXEC : S_RX_HI;
            S_EXEC:                            nxt = S_TX_ARM;
            S_TX_ARM: if (s_rw && !s_hs1)      nxt = S_TX_HI;
            S_TX_HI:  if (s_hs1)               nxt = S_TX_LO;
            S_TX_LO:  if (!s_hs1)              nxt = (idx == IW'(TX_BYTES)) ? S_IDLE : S_TX_ARM;
            default:                           nxt = S_IDLE;
        endcase
        if (!s_rstn) nxt = S_IDLE;
    end

    assign rx_take = (st == S_RX_HI) && (nxt == S_RX_LO);
    assign tx_done = (st == S_TX_HI) && (nxt == S_TX_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            idx  <= '0;
            rx_q <= '0;
            tx_q <= '0;
            hs2  <= 1'b0;
            ack  <= 1'b0;
        end else begin
            st  <= nxt;
            hs2 <= (nxt == S_RX_LO) || (nxt == S_TX_HI);
            ack <= (nxt != S_IDLE);
            if (nxt == S_IDLE || st == S_EXEC)
                idx <= '0;
            else if (rx_take || tx_done)
                idx <= idx + 1'b1;
            if (rx_take)
                rx_q <= {bus_in, rx_q[RX_BITS-1:BYTE_W]};
            if (st == S_EXEC)
                tx_q <= rsp_d;
            else if (tx_done)
                tx_q <= {{BYTE_W{1'b0}}, tx_q[TX_BITS-1:BYTE_W]};
        end
    end

    // request decode and register access
    assign req      = req_t'(rx_q);
    assign status_d = make_status(req.op, req.addr, NREGS);
    assign req_ok   = (status_d == '0);
    assign rf_we    = (st == S_EXEC) && req_ok && (req.op == OP_WRITE);

    bbs_regfile #(.NREGS(NREGS), .DW(WORD_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (req.addr[AW-1:0]),
        .wdata (req.wdata),
        .raddr (req.addr[AW-1:0]),
        .rdata (rf_rdata)
    );

    always_comb begin
        rsp_d.status = status_d;
        if (!req_ok)
            rsp_d.rdata = '0;
        else if (req.op == OP_WRITE)
            rsp_d.rdata = req.wdata;
        else
            rsp_d.rdata = rf_rdata;
    end

    // pad control
    assign bus_oe  = s_rw && ((st == S_TX_ARM) || (st == S_TX_HI) || (st == S_TX_LO));
    assign bus_out = bus_oe ? tx_q[BYTE_W-1:0] : '0;

endmodule

// File: rtl/bytebus_reg_slave_chk.sv
module bytebus_reg_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       s_rstn,
    input logic       s_hs1,
    input logic       start_edge,
    input logic [7:0] bus_out,
    input logic       bus_oe,
    input logic       hs2,
    input logic       ack
);
    // R10: the pad is only driven inside a transaction
    assert_oe_in_txn_R10: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> ack);

    // R9: the slave strobe never appears outside a transaction
    assert_hs2_in_txn_R9: assert property (@(posedge clk) disable iff (rst)
        hs2 |-> ack);

    // R2: ack only rises after a detected start edge
    assert_ack_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(start_edge));

    // R3: during the request, hs2 rises only after host strobe was seen high
    assert_hs2_rx_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs2) && !bus_oe) |-> $past(s_hs1));

    // R5: the offered reply byte holds while hs2 stays high
    assert_tx_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (hs2 && bus_oe && $past(hs2) && $past(bus_oe)) |-> $stable(bus_out));

    // R11: a host abort clears the handshake outputs on the next cycle
    assert_hostrst_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !s_rstn |=> (!ack && !hs2));
endmodule

bind bytebus_reg_slave bytebus_reg_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .s_rstn     (s_rstn),
    .s_hs1      (s_hs1),
    .start_edge (start_edge),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .hs2        (hs2),
    .ack        (ack)
);

// File: tb/bytebus_reg_slave_tb.sv
module bytebus_reg_slave_tb;
    localparam int NREGS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_rst_n = 1'b1;
    logic       host_start = 1'b0;
    logic       host_rw = 1'b0;
    logic       host_hs1 = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe, hs2, ack;

    int total = 0;
    int bad = 0;
    logic [31:0] model [NREGS];

    always #2.5 clk = ~clk;

    bytebus_reg_slave #(.NREGS(NREGS)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_rst_n (host_rst_n),
        .host_start (host_start),
        .host_rw    (host_rw),
        .host_hs1   (host_hs1),
        .bus_in     (bus_in),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe),
        .hs2        (hs2),
        .ack        (ack)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_hs2(input logic v, input string req);
        int n = 0;
        while (hs2 !== v && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (hs2 !== v) check({req, " hs2 timeout"}, {63'b0, hs2}, {63'b0, v});
    endtask

    task automatic wait_ack_low();
        int n = 0;
        while (ack !== 1'b0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        check("R9 ack falls at end", {63'b0, ack}, 64'd0);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        host_start = 1'b1;
        idle(3);
        host_start = 1'b0;
        idle(4);
    endtask

    task automatic wr_byte(input logic [7:0] b);
        host_rw = 1'b0;
        bus_in  = b;
        idle(4);
        if (hs2 !== 1'b0 || bus_oe !== 1'b0)
            check("R3/R10 quiet before host strobe", {62'b0, hs2, bus_oe}, 64'd0);
        host_hs1 = 1'b1;
        wait_hs2(1'b1, "R3");
        host_hs1 = 1'b0;
        wait_hs2(1'b0, "R3");
    endtask

    task automatic rd_byte(input bit last, output logic [7:0] b);
        host_rw = 1'b1;
        wait_hs2(1'b1, "R5");
        if (bus_oe !== 1'b1) check("R10 drive during reply", {63'b0, bus_oe}, 64'd1);
        b = bus_out;
        host_hs1 = 1'b1;
        wait_hs2(1'b0, "R5");
        if (last) check("R9 ack held after last byte", {63'b0, ack}, 64'd1);
        host_hs1 = 1'b0;
    endtask

    task automatic send_req(input logic [7:0] op, input logic [7:0] addr, input logic [31:0] wd);
        wr_byte(op);
        wr_byte(addr);
        for (int i = 0; i < 4; i++) wr_byte(wd[i*8 +: 8]);
    endtask

    task automatic get_rsp(output logic [63:0] rsp);
        logic [7:0] b;
        rsp = '0;
        for (int i = 0; i < 8; i++) begin
            rd_byte(i == 7, b);
            rsp[i*8 +: 8] = b;
        end
        host_rw = 1'b0;
        wait_ack_low();
    endtask

    task automatic txn(input logic [7:0] op, input logic [7:0] addr, input logic [31:0] wd,
                       output logic [63:0] rsp);
        pulse_start();
        check("R2 ack after start", {63'b0, ack}, 64'd1);
        send_req(op, addr, wd);
        get_rsp(rsp);
    endtask

    task automatic host_abort();
        @(negedge clk);
        host_rst_n = 1'b0;
        idle(6);
        check("R11 abort clears ack/hs2", {62'b0, ack, hs2}, 64'd0);
        host_rst_n = 1'b1;
        host_hs1   = 1'b0;
        host_rw    = 1'b0;
        idle(6);
    endtask

    function automatic logic [31:0] pattern(input int a);
        return (32'h1000_0001 * 32'(a + 3)) ^ 32'hC3A5_5A3C;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] rsp;
        logic [7:0]  ops [3];
        logic [31:0] v;
        ops[0] = 8'h00; ops[1] = 8'h03; ops[2] = 8'hFF;
        for (int i = 0; i < NREGS; i++) model[i] = '0;

        idle(5);
        rst = 1'b0;
        idle(5);
        check("R1 reset outputs", {61'b0, ack, hs2, bus_oe}, 64'd0);

        // R1/R7: registers read zero after reset
        for (int a = 0; a < NREGS; a++) begin
            txn(8'h02, 8'(a), 32'hFFFF_FFFF, rsp);
            check("R1 reset register value", rsp, 64'd0);
        end

        // R7/R8: write sweep across valid and out-of-range indices
        for (int a = 0; a < NREGS + 2; a++) begin
            txn(8'h01, 8'(a), pattern(a), rsp);
            if (a < NREGS) begin
                model[a] = pattern(a);
                check("R7 write returns new value", rsp, {32'd0, pattern(a)});
            end else begin
                check("R8 bad index status", rsp, {32'd2, 32'd0});
            end
        end

        // R7: read sweep, twice to show reads change nothing
        for (int rep = 0; rep < 2; rep++) begin
            for (int a = 0; a < NREGS + 2; a++) begin
                txn(8'h02, 8'(a), 32'h0BAD_0BAD, rsp);
                if (a < NREGS) check("R7 read returns contents", rsp, {32'd0, model[a]});
                else           check("R8 bad index read", rsp, {32'd2, 32'd0});
            end
        end

        // R8: unknown opcodes, alone and with a bad index
        foreach (ops[k]) begin
            txn(ops[k], 8'd1, 32'h5555_AAAA, rsp);
            check("R8 unknown opcode status", rsp, {32'd1, 32'd0});
            txn(ops[k], 8'd12, 32'h5555_AAAA, rsp);
            check("R8 both error bits", rsp, {32'd3, 32'd0});
        end
        txn(8'h02, 8'd1, 32'd0, rsp);
        check("R8 register untouched by bad opcode", rsp, {32'd0, model[1]});

        // R4/R6: byte order on the wire
        txn(8'h01, 8'd4, 32'h4433_2211, rsp);
        model[4] = 32'h4433_2211;
        check("R6 first reply byte is data LSB", {56'd0, rsp[7:0]}, 64'h11);
        check("R4 word assembled LSB first", {32'd0, rsp[31:0]}, 64'h4433_2211);
        check("R6 status bytes follow data", {32'd0, rsp[63:32]}, 64'd0);

        // R10: bus stays released in reply phase while host_rw is write
        pulse_start();
        send_req(8'h02, 8'd4, 32'd0);
        idle(10);
        check("R10 no drive while rw=write", {62'b0, bus_oe, hs2}, 64'd0);
        get_rsp(rsp);
        check("R10 reply after rw switch", rsp, {32'd0, model[4]});

        // R2: start pulse inside a request is ignored
        pulse_start();
        wr_byte(8'h01);
        wr_byte(8'd6);
        pulse_start();
        wr_byte(8'h78); wr_byte(8'h56); wr_byte(8'h34); wr_byte(8'h12);
        get_rsp(rsp);
        model[6] = 32'h1234_5678;
        check("R2 start during txn ignored", rsp, {32'd0, 32'h1234_5678});

        // R11: abort in the middle of a request leaves registers alone
        pulse_start();
        wr_byte(8'h01);
        wr_byte(8'd2);
        wr_byte(8'hEE);
        host_abort();
        txn(8'h02, 8'd2, 32'd0, rsp);
        check("R11 aborted request wrote nothing", rsp, {32'd0, model[2]});

        // R11: abort in the reply phase keeps the committed write
        pulse_start();
        send_req(8'h01, 8'd3, 32'hCAFE_F00D);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] b;
            rd_byte(1'b0, b);
        end
        host_abort();
        model[3] = 32'hCAFE_F00D;
        txn(8'h02, 8'd3, 32'd0, rsp);
        check("R11 committed write survives abort", rsp, {32'd0, model[3]});

        // R1: synchronous reset clears registers
        @(negedge clk); rst = 1'b1; idle(3); rst = 1'b0; idle(4);
        check("R1 outputs after second reset", {61'b0, ack, hs2, bus_oe}, 64'd0);
        txn(8'h02, 8'd3, 32'd0, rsp);
        check("R1 register cleared", rsp, 64'd0);

        v = 32'd0;
        $display("test done: total=%0d bad=%0d", total, bad + int'(v));
        $finish;
    end
endmodule